// File: doc/BRIEF.md
# Palette Port Decoder and Pixel Byte-Lane Splitter

This block sits between a host I/O bus and three external colour look-up palettes, and between a 16-bit-per-pixel video stream and those same palettes. On the host side it watches an 8-bit I/O bus with a 10-bit port address. It turns accesses to three groups of four ports into registered chip selects, a 2-bit register offset and write or read strobes for the palettes. It returns palette read-back data to the host. Two further ports act as pure strobes: a write to one switches the pixel lane split on and a write to the other switches it off. The data value of these writes is ignored.

On the video side, bytes arrive one per clock with a valid flag and a flag that marks the low byte of a pixel. With the split on, the block pairs each low byte with the high byte that follows it. It presents the low byte on the low lane, which feeds the first palette group, and the high byte on the high lane, which feeds the second and third groups. Both lanes strobe in the same cycle. With the split off, every byte is passed on at the byte rate and only the low lane strobes.

No register can reset the block. All state comes from the synchronous reset input.

Top module: `palette_port_splitter`

## Requirements
- R1: After reset, hc_en, grp_wr, grp_rd, lo_vld and hi_vld are 0, grp_sel is 0 and io_rdata is 0xFF.
- R2: A write to port 0x302+8*g+r (g in 0..2, r in 0..3) gives, one cycle later, grp_wr=1, grp_sel with only bit g set, grp_reg=r and grp_wdata equal to the written byte.
- R3: A read of port 0x302+8*g+r gives grp_rd=1, grp_sel bit g and grp_reg=r one cycle later. Two cycles after the read, io_rdata holds byte g of pal_rdata (bits 8g+7:8g), as sampled in the cycle where grp_rd is high.
- R4: Any other port, whether an unassigned port in 0x300..0x31A or a port outside that range, behaves as follows. A write to it gives no grp_wr and leaves hc_en unchanged (except R5 and R6). A read of it gives no grp_rd, and io_rdata is 0xFF two cycles later.
- R5: A write of any value to port 0x319 makes hc_en 0 from the next cycle.
- R6: A write of any value to port 0x31A makes hc_en 1 from the next cycle.
- R7: With hc_en=1, a valid low byte L (vid_low=1) followed by a valid high byte H (vid_low=0) makes lo_idx=L, hi_idx=H, lo_vld=1 and hi_vld=1 in the cycle after H arrives.
- R8: With hc_en=0, each valid byte B, whatever vid_low is, makes lo_idx=B, hi_idx=B, lo_vld=1 and hi_vld=0 in the next cycle.
- R9: Neither lane strobes in the cycle after an invalid byte. With hc_en=1, neither lane strobes in the cycle after a low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the pixel bytes |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 10 | Host port address |
| io_wdata | input | 8 | Host write data |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_rdata | output | 8 | Read result, valid two cycles after io_rd |
| grp_sel | output | 3 | One-hot palette group select |
| grp_reg | output | 2 | Register offset within the group |
| grp_wdata | output | 8 | Write data forwarded to the palette |
| grp_wr | output | 1 | Palette write strobe |
| grp_rd | output | 1 | Palette read strobe |
| pal_rdata | input | 24 | Palette read-back bytes, group g in bits 8g+7:8g |
| hc_en | output | 1 | Lane-split enable |
| vid_byte | input | 8 | Incoming pixel byte |
| vid_valid | input | 1 | Byte strobe |
| vid_low | input | 1 | Marks the low byte of a pixel |
| lo_idx | output | 8 | Low-lane palette index |
| lo_vld | output | 1 | Low-lane index strobe |
| hi_idx | output | 8 | High-lane palette index |
| hi_vld | output | 1 | High-lane index strobe |

## Verification
The host side is swept over all 1024 port addresses, once with writes and once with reads. The written byte and the palette read-back bytes are derived from the address, so a wrong group, a wrong offset, a read-back from the wrong byte, or a stray hit on an unassigned or outside port each show as a distinct mismatch. The video side is swept over all 256 low-byte values with a distinct paired high byte, with the split both on and off. The paired sweep tells apart swapped lanes, a lost held low byte and a strobe that fires early. The split-off sweep toggles vid_low to show that the flag is ignored and that the high lane stays quiet.

// File: rtl/pds_pkg.sv
package pds_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned REG_W  = 2;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/pds_group_match.sv
module pds_group_match #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned BASE   = 'h302,
  parameter int unsigned NREG   = 4,
  parameter int unsigned REG_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [REG_W-1:0]  off
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] LAST_V = ADDR_W'(BASE + NREG - 1);

  always_comb begin
    hit = (addr >= BASE_V) && (addr <= LAST_V);
    off = REG_W'(addr - BASE_V);
  end
endmodule

// File: rtl/pds_io_decode.sv
module pds_io_decode #(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned N_GRP      = 3,
  parameter int unsigned GRP_FIRST  = 'h302,
  parameter int unsigned GRP_STRIDE = 8,
  parameter int unsigned GRP_REGS   = 4,
  parameter int unsigned WIN_LO     = 'h300,
  parameter int unsigned WIN_HI     = 'h31A,
  parameter int unsigned PORT_OFF   = 'h319,
  parameter int unsigned PORT_ON    = 'h31A
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [ADDR_W-1:0]                 io_addr,
  input  logic [pds_pkg::BYTE_W-1:0]        io_wdata,
  input  logic                              io_wr,
  input  logic                              io_rd,
  output logic [pds_pkg::BYTE_W-1:0]        io_rdata,
  output logic [N_GRP-1:0]                  grp_sel,
  output logic [pds_pkg::REG_W-1:0]         grp_reg,
  output logic [pds_pkg::BYTE_W-1:0]        grp_wdata,
  output logic                              grp_wr,
  output logic                              grp_rd,
  input  logic [N_GRP*pds_pkg::BYTE_W-1:0]  pal_rdata,
  output logic                              hc_en
);
  import pds_pkg::*;

  localparam int unsigned GIDX_W = (N_GRP > 1) ? $clog2(N_GRP) : 1;
  localparam logic [ADDR_W-1:0] WIN_LO_V = ADDR_W'(WIN_LO);
  localparam logic [ADDR_W-1:0] WIN_HI_V = ADDR_W'(WIN_HI);
  localparam logic [ADDR_W-1:0] OFF_V    = ADDR_W'(PORT_OFF);
  localparam logic [ADDR_W-1:0] ON_V     = ADDR_W'(PORT_ON);

  logic [N_GRP-1:0]            hit;
  logic [REG_W-1:0]            off [N_GRP];
  logic                        any_hit;
  logic [GIDX_W-1:0]           idx;
  logic [REG_W-1:0]            off_sel;
  logic                        in_win;
  logic                        rd_pend;
  logic                        rd_hit;
  logic [GIDX_W-1:0]           rd_idx;
  byte_t                       rd_byte;

  for (genvar g = 0; g < N_GRP; g++) begin : g_match
    pds_group_match #(
      .ADDR_W(ADDR_W),
      .BASE  (GRP_FIRST + g * GRP_STRIDE),
      .NREG  (GRP_REGS),
      .REG_W (REG_W)
    ) u_match (
      .addr(io_addr),
      .hit (hit[g]),
      .off (off[g])
    );
  end

  always_comb begin
    any_hit = |hit;
    idx     = '0;
    off_sel = '0;
    for (int g = 0; g < N_GRP; g++) begin
      if (hit[g]) begin
        idx     = GIDX_W'(g);
        off_sel = off[g];
      end
    end
    in_win = (io_addr >= WIN_LO_V) && (io_addr <= WIN_HI_V);
  end

  always_comb begin
    rd_byte = '1;
    for (int g = 0; g < N_GRP; g++) begin
      if (rd_idx == GIDX_W'(g)) rd_byte = pal_rdata[g*BYTE_W +: BYTE_W];
    end
  end

  // Stage 1: strobes toward the palettes and the split enable
  always_ff @(posedge clk) begin
    if (rst) begin
      grp_wr    <= 1'b0;
      grp_rd    <= 1'b0;
      grp_sel   <= '0;
      grp_reg   <= '0;
      grp_wdata <= '0;
      hc_en     <= 1'b0;
      rd_pend   <= 1'b0;
      rd_hit    <= 1'b0;
      rd_idx    <= '0;
    end else begin
      grp_wr  <= io_wr && any_hit;
      grp_rd  <= io_rd && any_hit;
      grp_sel <= (io_wr || io_rd) ? hit : '0;
      grp_reg <= off_sel;
      if (io_wr) grp_wdata <= io_wdata;
      rd_pend <= io_rd;
      rd_hit  <= io_rd && any_hit;
      rd_idx  <= idx;
      if (io_wr && in_win && io_addr == OFF_V)     hc_en <= 1'b0;
      else if (io_wr && in_win && io_addr == ON_V) hc_en <= 1'b1;
    end
  end

  // Stage 2: read-back capture
  always_ff @(posedge clk) begin
    if (rst)          io_rdata <= '1;
    else if (rd_pend) io_rdata <= rd_hit ? rd_byte : '1;
  end

  a_r2_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    (grp_wr || grp_rd) |-> $onehot(grp_sel));
  a_r4_outside_no_write: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr < WIN_LO_V) |=> !grp_wr);
  a_r4_nohit_reads_ff: assert property (@(posedge clk) disable iff (rst)
    (rd_pend && !rd_hit) |=> (io_rdata == '1));
  a_r5_hc_clear: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == OFF_V) |=> !hc_en);
  a_r6_hc_set: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == ON_V) |=> hc_en);
endmodule

// File: rtl/pds_lane_split.sv
module pds_lane_split #(
  parameter int unsigned BYTE_W = pds_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hc_en,
  input  logic [BYTE_W-1:0] vid_byte,
  input  logic              vid_valid,
  input  logic              vid_low,
  output logic [BYTE_W-1:0] lo_idx,
  output logic              lo_vld,
  output logic [BYTE_W-1:0] hi_idx,
  output logic              hi_vld
);
  logic [BYTE_W-1:0] held_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_idx  <= '0;
      hi_idx  <= '0;
      lo_vld  <= 1'b0;
      hi_vld  <= 1'b0;
      held_lo <= '0;
    end else begin
      lo_vld <= 1'b0;
      hi_vld <= 1'b0;
      if (vid_valid) begin
        if (!hc_en) begin
          lo_idx <= vid_byte;
          hi_idx <= vid_byte;
          lo_vld <= 1'b1;
        end else if (vid_low) begin
          held_lo <= vid_byte;
        end else begin
          lo_idx <= held_lo;
          hi_idx <= vid_byte;
          lo_vld <= 1'b1;
          hi_vld <= 1'b1;
        end
      end
    end
  end

  a_r7_lanes_paired: assert property (@(posedge clk) disable iff (rst)
    hi_vld |-> lo_vld);
  a_r8_hi_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !hc_en |=> !hi_vld);
  a_r9_no_byte_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !vid_valid |=> (!lo_vld && !hi_vld));
  a_r9_low_alone_quiet: assert property (@(posedge clk) disable iff (rst)
    (hc_en && vid_valid && vid_low) |=> !lo_vld);
endmodule

// File: rtl/palette_port_splitter.sv
module palette_port_splitter #(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned N_GRP      = 3,
  parameter int unsigned GRP_FIRST  = 'h302,
  parameter int unsigned GRP_STRIDE = 8,
  parameter int unsigned GRP_REGS   = 4,
  parameter int unsigned WIN_LO     = 'h300,
  parameter int unsigned WIN_HI     = 'h31A,
  parameter int unsigned PORT_OFF   = 'h319,
  parameter int unsigned PORT_ON    = 'h31A,
  parameter int unsigned BYTE_W     = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         io_addr,
  input  logic [BYTE_W-1:0]         io_wdata,
  input  logic                      io_wr,
  input  logic                      io_rd,
  output logic [BYTE_W-1:0]         io_rdata,
  output logic [N_GRP-1:0]          grp_sel,
  output logic [1:0]                grp_reg,
  output logic [BYTE_W-1:0]         grp_wdata,
  output logic                      grp_wr,
  output logic                      grp_rd,
  input  logic [N_GRP*BYTE_W-1:0]   pal_rdata,
  output logic                      hc_en,
  input  logic [BYTE_W-1:0]         vid_byte,
  input  logic                      vid_valid,
  input  logic                      vid_low,
  output logic [BYTE_W-1:0]         lo_idx,
  output logic                      lo_vld,
  output logic [BYTE_W-1:0]         hi_idx,
  output logic                      hi_vld
);
  pds_io_decode #(
    .ADDR_W    (ADDR_W),
    .N_GRP     (N_GRP),
    .GRP_FIRST (GRP_FIRST),
    .GRP_STRIDE(GRP_STRIDE),
    .GRP_REGS  (GRP_REGS),
    .WIN_LO    (WIN_LO),
    .WIN_HI    (WIN_HI),
    .PORT_OFF  (PORT_OFF),
    .PORT_ON   (PORT_ON)
  ) u_dec (
    .clk      (clk),
    .rst      (rst),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_rdata (io_rdata),
    .grp_sel  (grp_sel),
    .grp_reg  (grp_reg),
    .grp_wdata(grp_wdata),
    .grp_wr   (grp_wr),
    .grp_rd   (grp_rd),
    .pal_rdata(pal_rdata),
    .hc_en    (hc_en)
  );

  pds_lane_split #(
    .BYTE_W(BYTE_W)
  ) u_split (
    .clk      (clk),
    .rst      (rst),
    .hc_en    (hc_en),
    .vid_byte (vid_byte),
    .vid_valid(vid_valid),
    .vid_low  (vid_low),
    .lo_idx   (lo_idx),
    .lo_vld   (lo_vld),
    .hi_idx   (hi_idx),
    .hi_vld   (hi_vld)
  );
endmodule

// File: tb/palette_port_splitter_bench.sv
module palette_port_splitter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic [2:0]  grp_sel;
  logic [1:0]  grp_reg;
  logic [7:0]  grp_wdata;
  logic        grp_wr;
  logic        grp_rd;
  logic [23:0] pal_rdata = '0;
  logic        hc_en;
  logic [7:0]  vid_byte = '0;
  logic        vid_valid = 1'b0;
  logic        vid_low = 1'b0;
  logic [7:0]  lo_idx;
  logic        lo_vld;
  logic [7:0]  hi_idx;
  logic        hi_vld;

  int total = 0;
  int bad   = 0;
  bit exp_hc = 1'b0;

  always #2.5 clk = ~clk;

  palette_port_splitter u_palette_port_splitter (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .grp_sel(grp_sel),
    .grp_reg(grp_reg), .grp_wdata(grp_wdata), .grp_wr(grp_wr), .grp_rd(grp_rd),
    .pal_rdata(pal_rdata), .hc_en(hc_en), .vid_byte(vid_byte),
    .vid_valid(vid_valid), .vid_low(vid_low), .lo_idx(lo_idx), .lo_vld(lo_vld),
    .hi_idx(hi_idx), .hi_vld(hi_vld)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // expected group of a port: returns -1 when none
  function automatic int grp_of(input int a);
    for (int g = 0; g < 3; g++) begin
      if (a >= 'h302 + 8*g && a <= 'h305 + 8*g) return g;
    end
    return -1;
  endfunction

  task automatic host_write(input int a, input int d);
    io_addr = 10'(a); io_wdata = 8'(d); io_wr = 1'b1;
    tick();
    io_wr = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); tick(); tick();
    rst = 1'b0;
    // R1 reset state
    chk(hc_en == 0, "R1 hc_en", hc_en, 0);
    chk(!grp_wr && !grp_rd && grp_sel == 0, "R1 strobes", {grp_wr, grp_rd, grp_sel}, 0);
    chk(!lo_vld && !hi_vld, "R1 lanes", {lo_vld, hi_vld}, 0);
    chk(io_rdata == 8'hFF, "R1 rdata", io_rdata, 'hFF);

    // R6 then R5 with extreme data values
    host_write('h31A, 'h00); exp_hc = 1;
    chk(hc_en == 1, "R6 set data 00", hc_en, 1);
    host_write('h319, 'hFF); exp_hc = 0;
    chk(hc_en == 0, "R5 clear data FF", hc_en, 0);
    host_write('h31A, 'hFF); exp_hc = 1;
    chk(hc_en == 1, "R6 set data FF", hc_en, 1);

    // Write sweep: R2, R4, R5, R6
    for (int a = 0; a < 1024; a++) begin
      int g;
      int d;
      g = grp_of(a);
      d = (a & 'hFF) ^ 'h5A;
      host_write(a, d);
      if (a == 'h319) exp_hc = 0;
      if (a == 'h31A) exp_hc = 1;
      if (g >= 0) begin
        chk(grp_wr == 1, "R2 grp_wr", grp_wr, 1);
        chk(grp_sel == 3'(1 << g), "R2 grp_sel", grp_sel, 1 << g);
        chk(grp_reg == 2'(a - ('h302 + 8*g)), "R2 grp_reg", grp_reg, a - ('h302 + 8*g));
        chk(grp_wdata == 8'(d), "R2 grp_wdata", grp_wdata, d);
      end else begin
        chk(grp_wr == 0, "R4 no write strobe", grp_wr, 0);
      end
      chk(hc_en == exp_hc, (a == 'h319) ? "R5 sweep" : (a == 'h31A) ? "R6 sweep" : "R4 hc_en kept",
          hc_en, exp_hc);
    end

    // Read sweep: R3, R4
    for (int a = 0; a < 1024; a++) begin
      int g;
      int e;
      g = grp_of(a);
      pal_rdata = {8'((a & 'hFF) ^ 'h33), 8'((a & 'hFF) ^ 'h22), 8'((a & 'hFF) ^ 'h11)};
      io_addr = 10'(a); io_rd = 1'b1;
      tick();
      io_rd = 1'b0;
      if (g >= 0) begin
        chk(grp_rd == 1 && grp_sel == 3'(1 << g), "R3 grp_rd/sel", {grp_rd, grp_sel}, {1'b1, 3'(1 << g)});
        chk(grp_reg == 2'(a - ('h302 + 8*g)), "R3 grp_reg", grp_reg, a - ('h302 + 8*g));
      end else begin
        chk(grp_rd == 0, "R4 no read strobe", grp_rd, 0);
      end
      tick();
      e = (g >= 0) ? ((a & 'hFF) ^ ('h11 * (g + 1))) : 'hFF;
      chk(io_rdata == 8'(e), (g >= 0) ? "R3 read-back" : "R4 reads FF", io_rdata, e);
    end

    // Split on: R7, R9
    host_write('h31A, 'h3C);
    chk(hc_en == 1, "R6 before video", hc_en, 1);
    for (int i = 0; i < 256; i++) begin
      vid_byte = 8'(i); vid_low = 1'b1; vid_valid = 1'b1;
      tick();
      chk(!lo_vld && !hi_vld, "R9 low byte alone", {lo_vld, hi_vld}, 0);
      vid_byte = 8'(i ^ 'hA5); vid_low = 1'b0;
      tick();
      vid_valid = 1'b0;
      chk(lo_vld && hi_vld, "R7 both strobes", {lo_vld, hi_vld}, 3);
      chk(lo_idx == 8'(i), "R7 low lane", lo_idx, i);
      chk(hi_idx == 8'(i ^ 'hA5), "R7 high lane", hi_idx, i ^ 'hA5);
      tick();
      chk(!lo_vld && !hi_vld, "R9 idle", {lo_vld, hi_vld}, 0);
    end

    // Split off: R8
    host_write('h319, 'hC3);
    chk(hc_en == 0, "R5 before video", hc_en, 0);
    for (int i = 0; i < 256; i++) begin
      vid_byte = 8'(255 - i); vid_low = i[0]; vid_valid = 1'b1;
      tick();
      chk(lo_vld && !hi_vld, "R8 strobes", {lo_vld, hi_vld}, 2);
      chk(lo_idx == 8'(255 - i) && hi_idx == 8'(255 - i), "R8 both lanes carry byte",
          {lo_idx, hi_idx}, {8'(255 - i), 8'(255 - i)});
    end
    vid_valid = 1'b0;
    tick();
    chk(!lo_vld && !hi_vld, "R9 idle after off", {lo_vld, hi_vld}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule